// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words that sits between two clock domains. The producer side pushes words on its own clock, and the consumer side pops them on a second clock. The two clocks may be the same net or fully unrelated. Reads and writes can happen on the same cycle. The read and write pointers cross between the domains as Gray code through two-flop synchronisers. Each flag is computed in the domain that acts on it: Empty and Almost Empty in the read domain, and Full, Half Full and Almost Full in the write domain.

The write port has two enables. The first is active low. The second selects between a normal push (high) and an offset load (low). An offset load stores the low bits of the write data into the Almost Empty threshold, and the next offset load stores into the Almost Full threshold, alternating after that. The read port has two active-low enables. Popped words land in a registered output stage, and an active-low output enable either drives that stage onto the data output or leaves the output at high impedance. An active-low asynchronous master reset empties the buffer and restores the default thresholds.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: A word is stored on a rising write-clock edge when `wr_en_a_n` is 0, `wr_ld_b` is 1 and the buffer is not full. Holding both enables active stores a new word on every write-clock cycle.
- R2: A word is popped into the output register on a rising read-clock edge only when `rd_en_a_n` and `rd_en_b_n` are both 0 and the buffer is not empty. Words leave in the order they were stored.
- R3: A push attempted while full and a pop attempted while empty are ignored. They change neither the stored words nor the output register.
- R4: `flag_empty` is 1 when the read domain sees zero words stored. `flag_full` is 1 when the write domain sees DEPTH words stored (DEPTH = 2**ADDR_W, 64 by default).
- R5: `flag_half` is 1 when the write domain sees more than DEPTH/2 words stored.
- R6: `flag_aempty` is 1 when the stored count is at most the Almost Empty offset. `flag_afull` is 1 when the stored count is at least DEPTH minus the Almost Full offset.
- R7: When `wr_en_a_n` is 0 and `wr_ld_b` is 0, the low ADDR_W bits of `wr_data` are loaded as an offset instead of being stored. The first load after reset sets the Almost Empty offset, the next load sets the Almost Full offset, and later loads keep alternating between the two.
- R8: When `out_en_n` is 1, every bit of `rd_data` is high impedance. When `out_en_n` is 0, `rd_data` shows the output register.
- R9: While `rst_n` is 0, the block clears both pointers and the output register and returns the load sequence to the Almost Empty offset. Both offsets go to 7. The flags read empty=1, aempty=1, half=0, afull=0, full=0.
- R10: With unrelated write and read clock periods and simultaneous pushes and pops, every word pushed is popped once, in order, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| wr_en_a_n | input | 1 | First write enable, active low |
| wr_ld_b | input | 1 | Second write enable: 1 pushes a word, 0 loads an offset |
| wr_data | input | 9 | Write data or offset value |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output enable, active low; 1 leaves rd_data at high impedance |
| rd_data | output | 9 | Registered read data |
| flag_empty | output | 1 | No words stored (read domain) |
| flag_aempty | output | 1 | Stored count at or below the Almost Empty offset (read domain) |
| flag_half | output | 1 | More than half full (write domain) |
| flag_afull | output | 1 | Stored count at or above DEPTH minus the Almost Full offset (write domain) |
| flag_full | output | 1 | DEPTH words stored (write domain) |

## Verification
The bench targets the exact counts where each flag changes. Almost Empty is checked just above and at the loaded threshold, Half Full at DEPTH/2+1, and Almost Full and Full at their last steps. An off-by-one comparison would show up as a flag one word early or late. It pushes past Full and pops past Empty, then drains the buffer word by word. A design that let an overflow push through would return an extra or a shifted word, and one that popped while empty would change the held output. It exercises the offset load sequence, both after a fresh reset and after loads, so that loads written to the wrong threshold or written into storage show up as wrong flags. It finishes with a run on unrelated clock periods, in which a bad pointer crossing would drop or repeat words.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Which threshold the next offset load targets
  typedef enum logic {
    LD_AE = 1'b0,
    LD_AF = 1'b1
  } ld_tgt_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic              wr_clk,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_evt) store[waddr] <= wdata;
  end

  // Registered output stage, loaded only by a qualified pop
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (rd_evt) q <= store[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 6,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              wr_en_a_n,
  input  logic              wr_ld_b,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] ae_ofs,
  output logic [ADDR_W-1:0] af_ofs,
  output logic              full,
  output logic              half,
  output logic              afull
);
  import dcf_pkg::*;

  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] occupancy(input logic [PW-1:0] head,
                                               input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  logic [PW-1:0] wbin;
  logic [PW-1:0] rbin_w;
  logic [PW-1:0] occ_w;
  logic          wr_req;
  logic          ld_evt;
  ld_tgt_e       ld_sel;
  logic [ADDR_W-1:0] ld_val;

  assign wr_req = !wr_en_a_n && wr_ld_b;
  assign ld_evt = !wr_en_a_n && !wr_ld_b;
  assign wr_evt = wr_req && !full;
  assign ld_val = ADDR_W'(wr_data);

  assign rbin_w = gray2bin(rgray_sync);
  assign occ_w  = occupancy(wbin, rbin_w);
  assign full   = (occ_w == DEPTH_P);
  assign half   = (occ_w > HALF_P);
  assign afull  = (occ_w >= (DEPTH_P - {1'b0, af_ofs}));
  assign waddr  = wbin[ADDR_W-1:0];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_evt) begin
      wbin  <= wbin + 1'b1;
      wgray <= bin2gray(wbin + 1'b1);
    end
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ofs <= ADDR_W'(AE_DEF);
      af_ofs <= ADDR_W'(AF_DEF);
      ld_sel <= LD_AE;
    end else if (ld_evt) begin
      if (ld_sel == LD_AE) begin
        ae_ofs <= ld_val;
        ld_sel <= LD_AF;
      end else begin
        af_ofs <= ld_val;
        ld_sel <= LD_AE;
      end
    end
  end

  // R1: the write pointer never moves by more than one per write clock
  p_wptr_step_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wbin == $past(wbin)) || (wbin == $past(wbin) + 1'b1));

  // R3: a push attempted while full leaves the pointer alone
  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && wr_req) |=> $stable(wbin));

  // R7: an offset load never advances the write pointer
  p_load_no_push_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ld_evt |=> $stable(wbin));

  // R5/R6: a full buffer is also past half and almost full
  p_full_levels_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> (half && afull));

  // R10: the pointer sent across domains changes at most one bit per clock
  p_wgray_one_bit_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_en_a_n,
  input  logic              rd_en_b_n,
  input  logic [ADDR_W:0]   wgray_sync,
  input  logic [ADDR_W-1:0] ae_ofs,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W-1:0] raddr,
  output logic              rd_evt,
  output logic              empty,
  output logic              aempty
);
  localparam int PW = ADDR_W + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] occupancy(input logic [PW-1:0] head,
                                               input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  logic [PW-1:0] rbin;
  logic [PW-1:0] wbin_r;
  logic [PW-1:0] occ_r;
  logic          rd_req;

  assign wbin_r = gray2bin(wgray_sync);
  assign occ_r  = occupancy(wbin_r, rbin);
  assign empty  = (occ_r == '0);
  assign aempty = (occ_r <= {1'b0, ae_ofs});
  assign rd_req = !rd_en_a_n && !rd_en_b_n;
  assign rd_evt = rd_req && !empty;
  assign raddr  = rbin[ADDR_W-1:0];

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_evt) begin
      rbin  <= rbin + 1'b1;
      rgray <= bin2gray(rbin + 1'b1);
    end
  end

  // R3: a pop attempted while empty leaves the pointer alone
  p_no_underflow_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty && rd_req) |=> $stable(rbin));

  // R2: the read pointer moves by at most one per read clock
  p_rptr_step_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rbin == $past(rbin)) || (rbin == $past(rbin) + 1'b1));

  // R6: an empty buffer is always almost empty
  p_empty_is_ae_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |-> aempty);

  // R10: the read pointer sent across domains changes at most one bit
  p_rgray_one_bit_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dual_clk_flag_fifo.sv
module dual_clk_flag_fifo #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 6,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_a_n,
  input  logic              wr_ld_b,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_a_n,
  input  logic              rd_en_b_n,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              flag_empty,
  output logic              flag_aempty,
  output logic              flag_half,
  output logic              flag_afull,
  output logic              flag_full
);
  import dcf_pkg::*;

  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray;
  logic [PW-1:0]     rgray;
  logic [PW-1:0]     wgray_rs;
  logic [PW-1:0]     rgray_ws;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [ADDR_W-1:0] ae_ofs;
  logic [ADDR_W-1:0] af_ofs;
  logic              wr_evt;
  logic              rd_evt;
  logic [DATA_W-1:0] q_reg;

  dcf_wr_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)
  ) u_wr (
    .wr_clk     (wr_clk),
    .rst_n      (rst_n),
    .wr_en_a_n  (wr_en_a_n),
    .wr_ld_b    (wr_ld_b),
    .wr_data    (wr_data),
    .rgray_sync (rgray_ws),
    .wgray      (wgray),
    .waddr      (waddr),
    .wr_evt     (wr_evt),
    .ae_ofs     (ae_ofs),
    .af_ofs     (af_ofs),
    .full       (flag_full),
    .half       (flag_half),
    .afull      (flag_afull)
  );

  dcf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .rd_clk     (rd_clk),
    .rst_n      (rst_n),
    .rd_en_a_n  (rd_en_a_n),
    .rd_en_b_n  (rd_en_b_n),
    .wgray_sync (wgray_rs),
    .ae_ofs     (ae_ofs),
    .rgray      (rgray),
    .raddr      (raddr),
    .rd_evt     (rd_evt),
    .empty      (flag_empty),
    .aempty     (flag_aempty)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk (rd_clk), .rst_n (rst_n), .d (wgray), .q (wgray_rs)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk (wr_clk), .rst_n (rst_n), .d (rgray), .q (rgray_ws)
  );

  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk (wr_clk),
    .wr_evt (wr_evt),
    .waddr  (waddr),
    .wdata  (wr_data),
    .rd_clk (rd_clk),
    .rst_n  (rst_n),
    .rd_evt (rd_evt),
    .raddr  (raddr),
    .q      (q_reg)
  );

  // R8: output stage driven only while the output enable is active
  assign rd_data = out_en_n ? {DATA_W{1'bz}} : q_reg;

  // R3/R2: the output register holds its value unless a pop was granted
  p_hold_without_pop_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !$past(rd_evt) |-> (q_reg == $past(q_reg)));
endmodule

// File: tb/dual_clk_flag_fifo_tb.sv
module dual_clk_flag_fifo_tb_top;
  localparam int DW = 9;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en_a_n = 1'b1;
  logic          wr_ld_b = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en_a_n = 1'b1;
  logic          rd_en_b_n = 1'b1;
  logic          out_en_n = 1'b0;
  wire  [DW-1:0] rd_data;
  logic          flag_empty, flag_aempty, flag_half, flag_afull, flag_full;

  int rd_half = 2;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  dual_clk_flag_fifo dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_a_n(wr_en_a_n), .wr_ld_b(wr_ld_b), .wr_data(wr_data),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n),
    .rd_data(rd_data), .flag_empty(flag_empty), .flag_aempty(flag_aempty),
    .flag_half(flag_half), .flag_afull(flag_afull), .flag_full(flag_full)
  );

  // Vector: {op[1:0], count[7:0], base[8:0], flags{E,AE,H,AF,F}[4:0], last_read[8:0]}
  localparam logic [1:0] OP_LD = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam int NV = 13;
  localparam logic [32:0] VEC [NV] = '{
    {OP_LD, 8'd1,  9'h003, 5'b11000, 9'h000},  // R7 AE offset = 3
    {OP_LD, 8'd1,  9'h005, 5'b11000, 9'h000},  // R7 AF offset = 5
    {OP_WR, 8'd1,  9'h100, 5'b01000, 9'h000},  // count 1
    {OP_WR, 8'd3,  9'h101, 5'b00000, 9'h000},  // count 4 > AE 3
    {OP_RD, 8'd1,  9'h000, 5'b01000, 9'h100},  // count 3
    {OP_WR, 8'd30, 9'h040, 5'b00100, 9'h000},  // count 33 > half
    {OP_WR, 8'd26, 9'h080, 5'b00110, 9'h000},  // count 59 = 64-5
    {OP_WR, 8'd5,  9'h1F0, 5'b00111, 9'h000},  // count 64 full
    {OP_WR, 8'd2,  9'h0AA, 5'b00111, 9'h000},  // R3 pushes dropped
    {OP_RD, 8'd3,  9'h000, 5'b00110, 9'h103},  // count 61
    {OP_RD, 8'd30, 9'h000, 5'b00000, 9'h05D},  // count 31
    {OP_RD, 8'd31, 9'h000, 5'b11000, 9'h1F4},  // count 0
    {OP_RD, 8'd2,  9'h000, 5'b11000, 9'h1F4}   // R3 pops ignored
  };

  function automatic logic [4:0] flags_now();
    return {flag_empty, flag_aempty, flag_half, flag_afull, flag_full};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en_a_n = 1'b1; wr_ld_b = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
  endtask

  task automatic run_op(input logic [1:0] op, input int cnt, input logic [8:0] base);
    for (int i = 0; i < cnt; i++) begin
      @(negedge wr_clk);
      idle_inputs();
      if (op == OP_LD) begin wr_en_a_n = 1'b0; wr_ld_b = 1'b0; wr_data = 9'(base + i); end
      if (op == OP_WR) begin wr_en_a_n = 1'b0; wr_ld_b = 1'b1; wr_data = 9'(base + i); end
      if (op == OP_RD) begin rd_en_a_n = 1'b0; rd_en_b_n = 1'b0; end
    end
    @(negedge wr_clk);
    idle_inputs();
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge wr_clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge wr_clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    // R9 reset state
    chk("R9 flags after reset", 32'(flags_now()), 32'(5'b11000));
    chk("R9 output register after reset", 32'(rd_data), 32'h0);

    // Vector table: R1..R7
    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][32:31], int'(VEC[v][30:23]), VEC[v][22:14]);
      chk($sformatf("R4/R5/R6 flags vector %0d", v), 32'(flags_now()), 32'(VEC[v][13:9]));
      if (VEC[v][32:31] == OP_RD)
        chk($sformatf("R2/R3 read data vector %0d", v), 32'(rd_data), 32'(VEC[v][8:0]));
    end

    // R8 output enable
    out_en_n = 1'b1; #1;
    checks++;
    if (rd_data !== {DW{1'bz}}) begin
      errors++;
      $display("FAIL R8 hiz: actual=%b expected=zzzzzzzzz", rd_data);
    end
    out_en_n = 1'b0; #1;
    chk("R8 driven again", 32'(rd_data), 32'h1F4);

    // R1 push needs first enable low
    @(negedge wr_clk); wr_en_a_n = 1'b1; wr_ld_b = 1'b1; wr_data = 9'h055;
    @(negedge wr_clk); idle_inputs();
    repeat (4) @(negedge wr_clk);
    chk("R1 no push with first enable high", 32'(flag_empty), 32'h1);
    run_op(OP_WR, 1, 9'h055);
    chk("R1 push stored", 32'(flag_empty), 32'h0);

    // R2 pop needs both read enables low
    @(negedge wr_clk); rd_en_a_n = 1'b0; rd_en_b_n = 1'b1;
    @(negedge wr_clk); idle_inputs();
    repeat (4) @(negedge wr_clk);
    chk("R2 no pop with one enable high: data", 32'(rd_data), 32'h1F4);
    chk("R2 no pop with one enable high: empty", 32'(flag_empty), 32'h0);
    run_op(OP_RD, 1, 9'h000);
    chk("R2 pop data", 32'(rd_data), 32'h055);
    chk("R4 empty after pop", 32'(flag_empty), 32'h1);

    // R9 mid-stream reset with defaults restored
    run_op(OP_WR, 3, 9'h011);
    do_reset();
    chk("R9 flags after mid reset", 32'(flags_now()), 32'(5'b11000));
    chk("R9 output cleared", 32'(rd_data), 32'h0);
    run_op(OP_WR, 7, 9'h020);
    chk("R9 default AE offset 7 at count 7", 32'(flag_aempty), 32'h1);
    run_op(OP_WR, 1, 9'h027);
    chk("R6 AE clears at count 8", 32'(flag_aempty), 32'h0);
    run_op(OP_LD, 1, 9'h00A);
    chk("R7 first load after reset targets AE", 32'(flag_aempty), 32'h1);
    chk("R7 load stores nothing", 32'(flag_empty), 32'h0);

    // R10 unrelated clocks, simultaneous traffic
    do_reset();
    rd_half = 3;
    repeat (4) @(negedge rd_clk);
    fork
      begin : writer
        int sent = 0;
        while (sent < 40) begin
          @(negedge wr_clk);
          if (!flag_full) begin
            wr_en_a_n = 1'b0; wr_ld_b = 1'b1; wr_data = 9'((sent * 7 + 3) & 9'h1FF);
            sent++;
          end else begin
            wr_en_a_n = 1'b1;
          end
        end
        @(negedge wr_clk); wr_en_a_n = 1'b1;
      end
      begin : reader
        int got = 0;
        int issued = 0;
        bit pend = 1'b0;
        while (got < 40) begin
          @(negedge rd_clk);
          if (pend) begin
            chk($sformatf("R10 word %0d", got), 32'(rd_data), 32'((got * 7 + 3) & 9'h1FF));
            got++;
          end
          pend = (!flag_empty && issued < 40);
          if (pend) issued++;
          rd_en_a_n = !pend; rd_en_b_n = !pend;
        end
      end
    join
    repeat (6) @(negedge rd_clk);
    chk("R10 drained", 32'(flag_empty), 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule